// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell of a small programmable logic array. The array in front of it supplies a sum term, which is the OR of the product terms routed to this cell. The array also supplies a product term that controls the output enable, and two product terms shared by all cells: an asynchronous clear and a synchronous set. The cell holds one D flip-flop that can be clocked from either of two clock inputs. A polarity stage and an output multiplexer choose what drives the pin. A feedback multiplexer chooses what goes back into the array, and both the true and the inverted form are returned.

Four static configuration bits set the cell's behaviour. One bit picks registered or combinational drive, one picks the output polarity, one picks the clock, and one picks the feedback source. The feedback bit has opposite meanings in the two modes. The clear and set terms act on the flip-flop itself, before the polarity stage, so the level seen at the pin after a clear depends on the polarity chosen. An active-low power-up reset clears the flip-flop. A test preload port loads any chosen state into the flip-flop on a clock edge.

Top module: `io_macrocell`

## Requirements
- R1: With cfg_i[1]=0 the pin value follows the flip-flop and changes only on an edge of the selected clock. With cfg_i[1]=1 the pin value follows sum_i directly, without waiting for a clock edge.
- R2: With cfg_i[0]=1 the pin shows the selected source unchanged. With cfg_i[0]=0 it shows the inverse. This holds in both modes.
- R3: With cfg_i[2]=1 the flip-flop captures on rising edges of clk1_i only. With cfg_i[2]=0 it captures on rising edges of clk2_i only.
- R4: The feedback is taken from pin_i in two cases: cfg_i[1]=0 with cfg_i[3]=0, and cfg_i[1]=1 with cfg_i[3]=1. In the other two cases the feedback is the inverted flip-flop output.
- R5: When ar_term_i is high the flip-flop is cleared to 0 at once, without a clock edge. The clear takes priority over sp_term_i and over the preload port.
- R6: When sp_term_i is high and ar_term_i is low, the next rising edge of the selected clock sets the flip-flop to 1.
- R7: The clear and set act on the flip-flop before the polarity stage. A cleared flip-flop therefore gives pin_o=1 when cfg_i[0]=0.
- R8: pin_oe_o follows oe_term_i in every mode. A term held high makes the cell a fixed output, held low makes it an input, and driven by logic makes it a dynamic I/O.
- R9: While rst_ni is low the flip-flop is held at 0 whatever the clocks and other inputs do.
- R10: When pl_en_i is high on a selected clock edge, the flip-flop takes pl_val_i. This overrides both sum_i and sp_term_i.
- R11: fb_n_o is always the complement of fb_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk1_i | input | 1 | First clock source |
| clk2_i | input | 1 | Second clock source |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| cfg_i | input | 4 | Configuration: [0] polarity, [1] mode, [2] clock select, [3] feedback select |
| sum_i | input | 1 | Sum term from the array |
| oe_term_i | input | 1 | Output-enable product term |
| ar_term_i | input | 1 | Shared asynchronous clear term |
| sp_term_i | input | 1 | Shared synchronous set term |
| pl_en_i | input | 1 | Test preload enable |
| pl_val_i | input | 1 | Test preload value |
| pin_i | input | 1 | Level sensed at the pad |
| pin_o | output | 1 | Value driven to the pad |
| pin_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback to the array, true form |
| fb_n_o | output | 1 | Feedback to the array, inverted form |

## Verification
The bench aims at the points where the feedback bit swaps meaning between the two modes. In these cases a cell that decoded the bit only once would return the pad level where it should return the buried register, or the other way round. It asserts the clear in the middle of a cycle, together with the set and the preload, and checks the pin before any clock edge. A clear that waited for the clock, or that lost to the set, shows up here. The bench also clears and sets the flip-flop with active-low polarity selected: a design that applied the clear or set after the inverter would show the wrong pin level. Finally, it clocks the unselected clock to catch a clock multiplexer that is wired backwards, and it drives the preload against a conflicting set to confirm which of the two wins.

// File: rtl/macro_pkg.sv
`timescale 1ns/1ps
package macro_pkg;
  typedef struct packed {
    logic fb_alt;    // [3] feedback select, meaning depends on mode
    logic clk_a;     // [2] 1: first clock, 0: second clock
    logic comb;      // [1] 1: combinational drive
    logic act_high;  // [0] 1: true polarity
  } arch_t;

  function automatic logic fb_from_pad(arch_t a);
    return a.comb ? a.fb_alt : ~a.fb_alt;
  endfunction
endpackage

// File: rtl/macro_clk_sel.sv
`timescale 1ns/1ps
module macro_clk_sel (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic sel_a_i,
  output logic clk_o
);
  // static selection; only changed while both clocks are low
  assign clk_o = sel_a_i ? clk_a_i : clk_b_i;
endmodule

// File: rtl/macro_ff.sv
`timescale 1ns/1ps
module macro_ff #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic pl_en_i,
  input  logic pl_val_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i)        q_o <= RESET_VAL;
    else if (pl_en_i) q_o <= pl_val_i;
    else if (set_i)   q_o <= 1'b1;
    else              q_o <= d_i;
  end
endmodule

// File: rtl/macro_out.sv
`timescale 1ns/1ps
module macro_out (
  input  logic comb_i,
  input  logic act_high_i,
  input  logic q_i,
  input  logic sum_i,
  output logic pin_o
);
  logic src;
  always_comb begin
    src   = comb_i ? sum_i : q_i;
    pin_o = act_high_i ? src : ~src;
  end
endmodule

// File: rtl/macro_fb.sv
`timescale 1ns/1ps
module macro_fb (
  input  logic from_pad_i,
  input  logic q_i,
  input  logic pad_i,
  output logic fb_o,
  output logic fb_n_o
);
  always_comb begin
    fb_o   = from_pad_i ? pad_i : ~q_i;
    fb_n_o = ~fb_o;
  end
endmodule

// File: rtl/io_macrocell.sv
`timescale 1ns/1ps
module io_macrocell
  import macro_pkg::*;
(
  input  logic       clk1_i,
  input  logic       clk2_i,
  input  logic       rst_ni,
  input  logic [3:0] cfg_i,
  input  logic       sum_i,
  input  logic       oe_term_i,
  input  logic       ar_term_i,
  input  logic       sp_term_i,
  input  logic       pl_en_i,
  input  logic       pl_val_i,
  input  logic       pin_i,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic       fb_o,
  output logic       fb_n_o
);
  arch_t arch;
  logic  reg_clk;
  logic  reg_clr;
  logic  reg_q;

  assign arch    = arch_t'(cfg_i);
  assign reg_clr = ~rst_ni | ar_term_i;

  macro_clk_sel u_clk (
    .clk_a_i (clk1_i),
    .clk_b_i (clk2_i),
    .sel_a_i (arch.clk_a),
    .clk_o   (reg_clk)
  );

  macro_ff #(.RESET_VAL(1'b0)) u_ff (
    .clk_i    (reg_clk),
    .clr_i    (reg_clr),
    .set_i    (sp_term_i),
    .pl_en_i  (pl_en_i),
    .pl_val_i (pl_val_i),
    .d_i      (sum_i),
    .q_o      (reg_q)
  );

  macro_out u_out (
    .comb_i     (arch.comb),
    .act_high_i (arch.act_high),
    .q_i        (reg_q),
    .sum_i      (sum_i),
    .pin_o      (pin_o)
  );

  macro_fb u_fb (
    .from_pad_i (fb_from_pad(arch)),
    .q_i        (reg_q),
    .pad_i      (pin_i),
    .fb_o       (fb_o),
    .fb_n_o     (fb_n_o)
  );

  assign pin_oe_o = oe_term_i;
endmodule

// File: rtl/io_macrocell_chk.sv
`timescale 1ns/1ps
module io_macrocell_chk (
  input logic       clk1_i,
  input logic       rst_ni,
  input logic [3:0] cfg_i,
  input logic       sum_i,
  input logic       ar_term_i,
  input logic       sp_term_i,
  input logic       pl_en_i,
  input logic       pl_val_i,
  input logic       q_i
);
  // R5: clear holds the register at zero
  a_r5_clear_forces_zero: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    ar_term_i |-> (q_i == 1'b0));

  // R1, R3: plain capture on the first clock
  a_r1_capture_sum: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (cfg_i[2] && !ar_term_i && !sp_term_i && !pl_en_i)
      |=> (ar_term_i || q_i == $past(sum_i)));

  // R6: set wins over data
  a_r6_preset_sets: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (cfg_i[2] && sp_term_i && !ar_term_i && !pl_en_i)
      |=> (ar_term_i || q_i == 1'b1));

  // R10: preload value captured
  a_r10_preload_loads: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (cfg_i[2] && pl_en_i && !ar_term_i)
      |=> (ar_term_i || q_i == $past(pl_val_i)));
endmodule

bind io_macrocell io_macrocell_chk chk_i (
  .clk1_i    (clk1_i),
  .rst_ni    (rst_ni),
  .cfg_i     (cfg_i),
  .sum_i     (sum_i),
  .ar_term_i (ar_term_i),
  .sp_term_i (sp_term_i),
  .pl_en_i   (pl_en_i),
  .pl_val_i  (pl_val_i),
  .q_i       (reg_q)
);

// File: tb/io_macrocell_tb_top.sv
`timescale 1ns/1ps
module io_macrocell_tb_top;
  logic       clk_1 = 1'b0;
  logic       clk_2 = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg   = 4'b0101;
  logic       sum = 1'b1, oe = 1'b0, ar = 1'b0, sp = 1'b0;
  logic       pl_en = 1'b0, pl_val = 1'b0, pin_in = 1'b0;
  logic       pin, pin_oe, fb, fb_n;
  int         n_checks = 0;
  int         n_errors = 0;

  always #5 clk_1 = ~clk_1;

  io_macrocell dut_i (
    .clk1_i(clk_1), .clk2_i(clk_2), .rst_ni(rst_n), .cfg_i(cfg),
    .sum_i(sum), .oe_term_i(oe), .ar_term_i(ar), .sp_term_i(sp),
    .pl_en_i(pl_en), .pl_val_i(pl_val), .pin_i(pin_in),
    .pin_o(pin), .pin_oe_o(pin_oe), .fb_o(fb), .fb_n_o(fb_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_edge(); @(negedge clk_1); endtask
  task automatic tick(); @(posedge clk_1); #1; endtask
  task automatic pulse_clk2(); #2 clk_2 = 1'b1; #2 clk_2 = 1'b0; #1; endtask

  task automatic t_reset();
    repeat (2) tick();
    chk("R9 reset holds zero", pin, 1'b0);
    drive_edge(); cfg = 4'b0100; #1;
    chk("R7 cleared reg active-low pin", pin, 1'b1);
    drive_edge(); rst_n = 1'b1; cfg = 4'b1101; sum = 1'b0;
    tick();
  endtask

  task automatic t_registered();
    drive_edge(); sum = 1'b1; #1;
    chk("R1 registered waits for edge", pin, 1'b0);
    tick();
    chk("R1 registered captures", pin, 1'b1);
    chk("R4 reg mode cfg3=1 inverted q", fb, 1'b0);
    chk("R11 complement", fb_n, 1'b1);
    drive_edge(); cfg = 4'b1100; #1;
    chk("R2 registered inverted", pin, 1'b0);
    drive_edge(); sum = 1'b0;
    tick();
    chk("R2 registered inverted low q", pin, 1'b1);
  endtask

  task automatic t_comb();
    drive_edge(); cfg = 4'b0011; sum = 1'b1; #1;
    chk("R1 comb follows sum high", pin, 1'b1);
    sum = 1'b0; #1;
    chk("R1 comb follows sum low", pin, 1'b0);
    cfg = 4'b0010; #1;
    chk("R2 comb inverted", pin, 1'b1);
    chk("R4 comb cfg3=0 inverted q", fb, 1'b1);
    cfg = 4'b1010; pin_in = 1'b0; #1;
    chk("R4 comb cfg3=1 pad low", fb, 1'b0);
    pin_in = 1'b1; #1;
    chk("R4 comb cfg3=1 pad high", fb, 1'b1);
    chk("R11 complement comb", fb_n, 1'b0);
  endtask

  task automatic t_clksel();
    drive_edge(); cfg = 4'b0001; sum = 1'b1;
    tick();
    chk("R3 first clock ignored", pin, 1'b0);
    pin_in = 1'b1; #1;
    chk("R4 reg cfg3=0 pad high", fb, 1'b1);
    pin_in = 1'b0; #1;
    chk("R4 reg cfg3=0 pad low", fb, 1'b0);
    drive_edge(); pulse_clk2();
    chk("R3 second clock captures", pin, 1'b1);
    drive_edge(); cfg = 4'b0101;
  endtask

  task automatic t_clear();
    drive_edge(); sum = 1'b1; #1;
    ar = 1'b1; sp = 1'b1; pl_en = 1'b1; pl_val = 1'b1; #1;
    chk("R5 clear without edge", pin, 1'b0);
    tick();
    chk("R5 clear beats set and preload", pin, 1'b0);
    drive_edge(); ar = 1'b0; sp = 1'b0; pl_en = 1'b0; sum = 1'b0;
    tick();
  endtask

  task automatic t_preset();
    drive_edge(); cfg = 4'b0100; #1;
    chk("R7 cleared q shows high", pin, 1'b1);
    sp = 1'b1;
    tick();
    chk("R6 set gives q=1 active-low pin", pin, 1'b0);
    drive_edge(); sp = 1'b0;
    tick();
    chk("R6 set released", pin, 1'b1);
  endtask

  task automatic t_preload();
    drive_edge(); cfg = 4'b0101; pl_en = 1'b1; pl_val = 1'b0; sum = 1'b1; sp = 1'b1;
    tick();
    chk("R10 preload 0 beats sum and set", pin, 1'b0);
    drive_edge(); pl_val = 1'b1; sum = 1'b0; sp = 1'b0;
    tick();
    chk("R10 preload 1 beats sum", pin, 1'b1);
    drive_edge(); pl_en = 1'b0;
    tick();
    chk("R10 preload released", pin, 1'b0);
  endtask

  task automatic t_oe();
    drive_edge(); oe = 1'b1; #1;
    chk("R8 enable high", pin_oe, 1'b1);
    oe = 1'b0; #1;
    chk("R8 enable low", pin_oe, 1'b0);
    cfg = 4'b0011; oe = 1'b1; #1;
    chk("R8 enable in comb mode", pin_oe, 1'b1);
    drive_edge(); cfg = 4'b0101; oe = 1'b0;
  endtask

  task automatic t_rst_mid();
    drive_edge(); sum = 1'b1;
    tick();
    chk("R9 setup q=1", pin, 1'b1);
    drive_edge(); rst_n = 1'b0; #1;
    chk("R9 reset clears mid run", pin, 1'b0);
    tick();
    chk("R9 reset holds through edge", pin, 1'b0);
    drive_edge(); rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_registered();
    t_comb();
    t_clksel();
    t_clear();
    t_preset();
    t_preload();
    t_oe();
    t_rst_mid();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule